// File: doc/BRIEF.md
# High-Half Byte Manipulation Unit

This unit executes the "high" byte-lane group of a 64-bit integer pipeline: mask-high, insert-high and extract-high, each at word (16-bit), longword (32-bit) and quadword (64-bit) size. These operations handle the part of an unaligned field that spills across a quadword boundary. Operand A carries the data. The low three bits of operand B give a byte offset.

A 7-bit function code selects the operation. When the input strobe is high, the result is captured and presented one clock later together with a valid flag. A function code outside the group does not fail silently: it sets an illegal-function flag and yields a zero result, so the pipeline's exception logic can act on it.

Top module: `bytehi_unit`

## Requirements
- R1: While reset is asserted and after its release, until the first accepted input, `out_vld`, `out_illegal` and `out_res` are all zero.
- R2: `out_vld` is high in the cycle after each cycle in which `in_vld` is high, and low otherwise.
- R3: The function codes are decoded as follows. 0x57, 0x67 and 0x77 are insert-high for word, longword and quadword. 0x5A, 0x6A and 0x7A are extract-high for the same three sizes. 0x62 is mask-high longword and 0x72 is mask-high quadword. Every other code, 0x52 included, is illegal and sets `out_illegal`.
- R4: The byte offset `o` is `in_b[2:0]` only, and bits 63:3 of `in_b` have no effect on the result. For insert-high and extract-high the shift distance is `(64 - 8*o) mod 64` bits.
- R5: Extract-high returns `in_a` shifted left by the shift distance, truncated to the low 16, 32 or 64 bits for word, longword or quadword.
- R6: Insert-high with a nonzero offset returns `in_a` truncated to 16, 32 or 64 bits, shifted right by the shift distance. With offset 0 it returns zero.
- R7: Mask-high forms a byte select of 0x0F (longword) or 0xFF (quadword), shifted right by `8 - o`. It returns `in_a` with each byte cleared whose select bit is set, where bit k stands for bits 8k+7:8k.
- R8: When `in_vld` is low, `out_res` and `out_illegal` keep their previous values.
- R9: An illegal function code gives `out_res` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_vld | input | 1 | Input strobe: operands and function code are valid |
| in_func | input | 7 | Function code |
| in_a | input | 64 | Data operand |
| in_b | input | 64 | Byte offset operand (bits 2:0 used) |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_res | output | 64 | Registered result |
| out_illegal | output | 1 | Registered illegal-function flag |

## Verification
The datapath has no state besides the output register, so a wrong decode, an inverted shift direction or a wrong offset complement shows at `out_res` in the very next cycle after the offending input. Every function code is paired with all eight offsets over several operand patterns, with random upper bits in operand B. This sweep exposes swapped insert/extract codes, a shift that is off by one byte, and a missing zero at offset 0 at once. A broken clock enable shows as a changed result in the first idle cycle after a transfer.

// File: rtl/bytehi_pkg.sv
package bytehi_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MSK  = 2'd1,
    OP_INS  = 2'd2,
    OP_EXT  = 2'd3
  } bh_op_e;

  typedef enum logic [1:0] {
    SZ_W = 2'd0,
    SZ_L = 2'd1,
    SZ_Q = 2'd2
  } bh_sz_e;

  localparam logic [6:0] FN_INS_W = 7'h57;
  localparam logic [6:0] FN_EXT_W = 7'h5A;
  localparam logic [6:0] FN_MSK_L = 7'h62;
  localparam logic [6:0] FN_INS_L = 7'h67;
  localparam logic [6:0] FN_EXT_L = 7'h6A;
  localparam logic [6:0] FN_MSK_Q = 7'h72;
  localparam logic [6:0] FN_INS_Q = 7'h77;
  localparam logic [6:0] FN_EXT_Q = 7'h7A;

endpackage

// File: rtl/bytehi_decode.sv
module bytehi_decode
  import bytehi_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] func,
  output bh_op_e            op,
  output bh_sz_e            sz,
  output logic              illegal
);

  always_comb begin
    op      = OP_NONE;
    sz      = SZ_Q;
    illegal = 1'b0;
    case (func)
      FN_INS_W: begin op = OP_INS; sz = SZ_W; end
      FN_EXT_W: begin op = OP_EXT; sz = SZ_W; end
      FN_MSK_L: begin op = OP_MSK; sz = SZ_L; end
      FN_INS_L: begin op = OP_INS; sz = SZ_L; end
      FN_EXT_L: begin op = OP_EXT; sz = SZ_L; end
      FN_MSK_Q: begin op = OP_MSK; sz = SZ_Q; end
      FN_INS_Q: begin op = OP_INS; sz = SZ_Q; end
      FN_EXT_Q: begin op = OP_EXT; sz = SZ_Q; end
      default:  illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/bytehi_lanes.sv
module bytehi_lanes
  import bytehi_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  bh_op_e                            op,
  input  bh_sz_e                            sz,
  input  logic [DATA_W-1:0]                 a,
  input  logic [$clog2(DATA_W/8)-1:0]       ofs,
  output logic [DATA_W-1:0]                 res
);

  localparam int NBYTES = DATA_W / 8;
  localparam int OFS_W  = $clog2(NBYTES);
  localparam int SH_W   = OFS_W + 3;
  localparam int N_W    = OFS_W + 1;

  logic [OFS_W-1:0]  ofs_neg;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] szmask;
  logic [NBYTES-1:0] base_sel;
  logic [N_W-1:0]    msk_n;
  logic [NBYTES-1:0] zap_sel;
  logic [DATA_W-1:0] zapped;
  logic [DATA_W-1:0] ext_v;
  logic [DATA_W-1:0] ins_v;

  // complemented byte offset -> bit shift distance
  assign ofs_neg = OFS_W'(0) - ofs;
  assign shamt   = {ofs_neg, 3'b000};

  always_comb begin
    case (sz)
      SZ_W:    szmask = {{(DATA_W-16){1'b0}}, {16{1'b1}}};
      SZ_L:    szmask = {{(DATA_W-32){1'b0}}, {32{1'b1}}};
      default: szmask = {DATA_W{1'b1}};
    endcase
  end

  always_comb begin
    case (sz)
      SZ_W:    base_sel = NBYTES'(2'b11);
      SZ_L:    base_sel = NBYTES'(4'hF);
      default: base_sel = {NBYTES{1'b1}};
    endcase
  end

  assign msk_n   = N_W'(NBYTES) - N_W'(ofs);
  assign zap_sel = base_sel >> msk_n;

  for (genvar k = 0; k < NBYTES; k++) begin : g_zap
    assign zapped[8*k +: 8] = zap_sel[k] ? 8'h00 : a[8*k +: 8];
  end

  assign ext_v = (a << shamt) & szmask;
  assign ins_v = (ofs == '0) ? '0 : ((a & szmask) >> shamt);

  always_comb begin
    case (op)
      OP_MSK:  res = zapped;
      OP_INS:  res = ins_v;
      OP_EXT:  res = ext_v;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/bytehi_unit.sv
module bytehi_unit
  import bytehi_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res,
  output logic              out_illegal
);

  localparam int OFS_W = $clog2(DATA_W / 8);

  bh_op_e            dec_op;
  bh_sz_e            dec_sz;
  logic              dec_ill;
  logic [DATA_W-1:0] lane_res;
  logic              unused_b_hi;

  logic              vld_d, vld_q;
  logic [DATA_W-1:0] res_d, res_q;
  logic              ill_d, ill_q;

  assign unused_b_hi = ^in_b[DATA_W-1:OFS_W];

  bytehi_decode #(.FUNC_W(FUNC_W)) u_dec (
    .func    (in_func),
    .op      (dec_op),
    .sz      (dec_sz),
    .illegal (dec_ill)
  );

  bytehi_lanes #(.DATA_W(DATA_W)) u_lanes (
    .op  (dec_op),
    .sz  (dec_sz),
    .a   (in_a),
    .ofs (in_b[OFS_W-1:0]),
    .res (lane_res)
  );

  // next state
  always_comb begin
    vld_d = in_vld;
    res_d = lane_res;
    ill_d = dec_ill;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ill_q <= 1'b0;
    end else if (in_vld) begin
      res_q <= res_d;
      ill_q <= ill_d;
    end
  end

  assign out_vld     = vld_q;
  assign out_res     = res_q;
  assign out_illegal = ill_q;

endmodule

// File: rtl/bytehi_chk.sv
module bytehi_chk #(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [FUNC_W-1:0] in_func,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res,
  input logic              out_illegal
);

  logic unused_chk_b;
  logic is_ins, is_msk, is_ext_w;

  assign unused_chk_b = ^in_b[DATA_W-1:3];
  assign is_ins   = (in_func == 7'h57) || (in_func == 7'h67) || (in_func == 7'h77);
  assign is_msk   = (in_func == 7'h62) || (in_func == 7'h72);
  assign is_ext_w = (in_func == 7'h5A);

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_res) && $stable(out_illegal)));

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_illegal) |-> (out_res == '0));

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (is_ins || is_msk || is_ext_w)) |=> !out_illegal);

  // R6
  ins_zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is_ins && (in_b[2:0] == 3'd0)) |=> (out_res == '0));

  // R5
  ext_word_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is_ext_w) |=> (out_res[DATA_W-1:16] == '0));

  // R7
  msk_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is_msk) |=> ((out_res & ~$past(in_a)) == '0));

endmodule

bind bytehi_unit bytehi_chk #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_chk (.*);

// File: tb/bytehi_unit_bench.sv
module bytehi_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [6:0]  in_func;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic        out_vld;
  logic [63:0] out_res;
  logic        out_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [63:0] rs = 64'h9E3779B97F4A7C15;

  always #4 clk = ~clk;

  bytehi_unit u_bytehi_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_func(in_func),
    .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_res(out_res),
    .out_illegal(out_illegal)
  );

  function automatic logic [63:0] zap(logic [63:0] a, logic [7:0] sel);
    logic [63:0] r = a;
    for (int k = 0; k < 8; k++) if (sel[k]) r[8*k +: 8] = 8'h00;
    return r;
  endfunction

  // returns {illegal, result}
  function automatic logic [64:0] ref_model(logic [6:0] f, logic [63:0] a, logic [63:0] b);
    int o  = int'(b[2:0]);
    int sh = (o == 0) ? 0 : 64 - 8 * o;
    logic [63:0] r = 64'd0;
    logic il = 1'b0;
    case (f)
      7'h57: r = (o == 0) ? 64'd0 : ((a & 64'hFFFF) >> sh);
      7'h67: r = (o == 0) ? 64'd0 : ((a & 64'hFFFF_FFFF) >> sh);
      7'h77: r = (o == 0) ? 64'd0 : (a >> sh);
      7'h5A: r = (a << sh) & 64'hFFFF;
      7'h6A: r = (a << sh) & 64'hFFFF_FFFF;
      7'h7A: r = a << sh;
      7'h62: r = zap(a, 8'h0F >> (8 - o));
      7'h72: r = zap(a, 8'hFF >> (8 - o));
      default: il = 1'b1;
    endcase
    return {il, r};
  endfunction

  function automatic string tag_of(logic [6:0] f, logic [63:0] b);
    case (f)
      7'h57, 7'h67, 7'h77: return (b[2:0] == 3'd0) ? "R6" : "R4/R6";
      7'h5A, 7'h6A, 7'h7A: return "R5";
      7'h62, 7'h72:        return "R7";
      default:             return "R3/R9";
    endcase
  endfunction

  task automatic next_rand();
    rs ^= rs << 13;
    rs ^= rs >> 7;
    rs ^= rs << 17;
  endtask

  task automatic check(string req, logic [65:0] act, logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {vld,ill,res}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [6:0] f, logic [63:0] a, logic [63:0] b);
    logic [64:0] e;
    @(negedge clk);
    in_vld = 1'b1; in_func = f; in_a = a; in_b = b;
    e = ref_model(f, a, b);
    @(negedge clk);
    in_vld = 1'b0;
    check(tag_of(f, b), {out_vld, out_illegal, out_res}, {1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    logic [64:0] e;
    rst_n = 1'b0; in_vld = 1'b0; in_func = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {out_vld, out_illegal, out_res}, 66'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_vld, out_illegal, out_res}, 66'd0);

    // R6 directed: insert at offset 0 yields zero; R4 upper B bits ignored
    apply(7'h77, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF8);
    apply(7'h57, 64'h0123_4567_89AB_CDEF, 64'd3);
    // R4: same offset with junk upper bits must match
    apply(7'h57, 64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0000_0003);
    // R3: 0x52 is not part of the group
    apply(7'h52, 64'h1234, 64'd7);

    // exhaustive codes x offsets x patterns (R3 R4 R5 R6 R7 R9)
    for (int f = 0; f < 128; f++) begin
      for (int o = 0; o < 8; o++) begin
        for (int p = 0; p < 5; p++) begin
          logic [63:0] a;
          next_rand();
          case (p)
            0: a = 64'hFFFF_FFFF_FFFF_FFFF;
            1: a = 64'h0807_0605_0403_0201;
            default: a = rs;
          endcase
          next_rand();
          apply(7'(f), a, {rs[63:3], 3'(o)});
        end
      end
    end

    // R8 and R2: idle cycle keeps result, drops valid
    apply(7'h7A, 64'hA5A5_0000_1111_2222, 64'd2);
    held = out_res;
    e = ref_model(7'h7A, 64'hA5A5_0000_1111_2222, 64'd2);
    in_func = 7'h00; in_a = 64'hFFFF; in_b = 64'd1;
    @(negedge clk);
    check("R8/R2", {out_vld, out_illegal, out_res}, {1'b0, e});
    @(negedge clk);
    check("R8", {1'b0, 1'b0, out_res}, {1'b0, 1'b0, held});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule